// File: doc/BRIEF.md
# Serial Flash Slave Interface Front-End

This block is the serial face of a flash-style memory device. It watches the host's select, serial clock and hold lines and turns the incoming bit stream into bytes for the memory core. The first byte of every selected transfer is the command byte; every later byte is a data byte (address or write data). For reads, the core supplies a byte at each byte boundary and the block shifts it back out to the host. Each output line has its own enable, so the pad logic outside can tri-state it.

All pin inputs are sampled on the system clock `clk`. The serial clock is handled as data, and its edges are found by comparing it with the value from the previous cycle. Bits come in on serial-clock rises and go out on serial-clock falls, most significant bit first. In the default single-line mode, input arrives on line 0 and output leaves on line 1. In dual mode, both lines carry two bits per serial clock, with line 1 carrying the more significant bit. The core asks for dual mode through `dual_req`. The block adopts that request at the first edge of each byte after the command.

A four-state machine controls the transfer:
- `ST_LOCK`: after reset. Nothing is accepted here. The transition `lock_release` goes to `ST_IDLE` once select is seen high.
- `ST_IDLE`: deselected. The transition `select` goes to `ST_CMD` when select falls.
- `ST_CMD`: shifting in the command byte. The transition `cmd_done` goes to `ST_DATA` after eight single-line bits.
- `ST_DATA`: byte-by-byte data transfer.

From `ST_CMD` and `ST_DATA`, the transition `deselect` returns to `ST_IDLE` whenever select rises.

A hold flag pauses a selected transfer without losing its place. The flag follows the hold pin, but only while the serial clock is low.

Top module: `spi_flash_fe`

## Requirements
- R1: While `cs_n` is high (after the cycle in which it rose), `io_oe` is 2'b00.
- R2: After reset, serial-clock edges are ignored and no `cmd_valid` is raised until `cs_n` has been seen high and then low again.
- R3: The first 8 serial-clock rises after select falls shift the command byte in from `io_i[0]`, MSB first. `cmd_valid` is then a one-cycle pulse with the byte on `rx_byte`. The command byte is always single-line, whatever `dual_req` is.
- R4: Each later complete byte raises `data_valid` for one cycle with the byte on `rx_byte`. `cmd_valid` and `data_valid` are never high together.
- R5: In dual mode, each rise samples `{io_i[1], io_i[0]}` as the next two bits, with bit 1 more significant, so a byte takes 4 rises. The mode for a byte is `dual_req` as sampled at that byte's first serial-clock edge.
- R6: `tx_byte` is captured on the rise that completes a byte. On the falls that follow, single mode drives it MSB first on `io_o[1]`, with `io_oe` = 2'b10 while `tx_en` is high in `ST_DATA`.
- R7: In dual mode, each fall drives two bits of the captured byte, the more significant on `io_o[1]` and the next on `io_o[0]`, with `io_oe` = 2'b11.
- R8: The hold flag follows `hold_n` low only while `sclk` is low. While held, `io_oe` is 2'b00 and serial-clock edges are ignored.
- R9: After hold is released, the transfer resumes with no bit lost or repeated, both for incoming bits and for outgoing bits.
- R10: A rise of `cs_n` at any point aborts the transfer, clears the bit counter and returns to single mode. The next selection starts with a fresh command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from host |
| sclk | input | 1 | Serial clock from host (idles low) |
| hold_n | input | 1 | Active-low pause request |
| io_i | input | 2 | Pad input values of data lines 1 and 0 |
| io_o | output | 2 | Values driven onto data lines 1 and 0 |
| io_oe | output | 2 | Output enables for data lines 1 and 0 |
| dual_req | input | 1 | Core asks for two-bit transfer on the following bytes |
| tx_en | input | 1 | Core asks the block to drive read data |
| tx_byte | input | BYTE_W | Next byte to send, captured at each byte boundary |
| rx_byte | output | BYTE_W | Last byte received |
| cmd_valid | output | 1 | One-cycle strobe: `rx_byte` holds the command |
| data_valid | output | 1 | One-cycle strobe: `rx_byte` holds a data byte |

## Verification
The assertions, and the block itself, assume that every pin input is already synchronous to `clk`. They also assume that `sclk` holds each level for at least two system clocks, so that a byte boundary, the state change it causes and the next edge never share a cycle. The bench drives all pins on falling edges of `clk` and keeps each `sclk` level for three cycles. It changes `cs_n` and `hold_n` only while `sclk` is steady. The exception is one deliberate hold request made while `sclk` is high, which checks that the request is deferred.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
    typedef enum logic [1:0] {
        ST_LOCK = 2'd0,
        ST_IDLE = 2'd1,
        ST_CMD  = 2'd2,
        ST_DATA = 2'd3
    } fe_state_t;
endpackage

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
    import spi_fe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_n,
    input  logic      sclk,
    input  logic      hold_n,
    input  logic      cmd_done,
    output fe_state_t state,
    output logic      held,
    output logic      rise,
    output logic      fall
);
    fe_state_t state_q, state_d;
    logic      sclk_q;
    logic      held_q;
    logic      active;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCK: if (cs_n)  state_d = ST_IDLE;          // lock_release
            ST_IDLE: if (!cs_n) state_d = ST_CMD;           // select
            ST_CMD: begin
                if (cs_n)          state_d = ST_IDLE;       // deselect
                else if (cmd_done) state_d = ST_DATA;       // cmd_done
            end
            ST_DATA: if (cs_n)  state_d = ST_IDLE;          // deselect
            default:            state_d = ST_LOCK;
        endcase
    end

    // state register, serial-clock history and hold flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCK;
            sclk_q  <= 1'b0;
            held_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            sclk_q  <= sclk;
            if (cs_n)
                held_q <= 1'b0;
            else if (!sclk)
                held_q <= !hold_n;
        end
    end

    // outputs
    always_comb begin
        active = (state_q == ST_CMD || state_q == ST_DATA) && !cs_n && !held_q;
        rise   = active && sclk && !sclk_q;
        fall   = active && !sclk && sclk_q;
        state  = state_q;
        held   = held_q;
    end

    assert_hold_at_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(held_q) && !$past(cs_n)) |-> !$past(sclk));

endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rise,
    input  logic              fall,
    input  logic [1:0]        io_i,
    input  logic              dual_req,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              cmd_pulse,
    output logic              data_pulse,
    output logic              eff_dual,
    output logic [1:0]        do_q
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam int HALF  = BYTE_W / 2;

    logic [CNT_W-1:0]  cnt;
    logic              mode_q;
    logic              past_cmd;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] sh_nxt;
    logic [BYTE_W-1:0] tx_sh;
    logic              last;

    always_comb begin
        eff_dual = past_cmd && ((cnt == '0) ? dual_req : mode_q);
        if (eff_dual) begin
            sh_nxt = {sh[BYTE_W-3:0], io_i[1], io_i[0]};
            last   = (cnt == CNT_W'(HALF - 1));
        end else begin
            sh_nxt = {sh[BYTE_W-2:0], io_i[0]};
            last   = (cnt == CNT_W'(BYTE_W - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            mode_q     <= 1'b0;
            past_cmd   <= 1'b0;
            sh         <= '0;
            tx_sh      <= '0;
            rx_byte    <= '0;
            cmd_pulse  <= 1'b0;
            data_pulse <= 1'b0;
            do_q       <= '0;
        end else begin
            cmd_pulse  <= 1'b0;
            data_pulse <= 1'b0;
            if (clr) begin
                cnt      <= '0;
                mode_q   <= 1'b0;
                past_cmd <= 1'b0;
            end else if (rise) begin
                if (cnt == '0)
                    mode_q <= eff_dual;
                if (last) begin
                    cnt        <= '0;
                    rx_byte    <= sh_nxt;
                    tx_sh      <= tx_byte;
                    past_cmd   <= 1'b1;
                    cmd_pulse  <= !past_cmd;
                    data_pulse <= past_cmd;
                end else begin
                    cnt <= cnt + 1'b1;
                    sh  <= sh_nxt;
                end
            end else if (fall) begin
                if (eff_dual) begin
                    do_q  <= tx_sh[BYTE_W-1 -: 2];
                    tx_sh <= {tx_sh[BYTE_W-3:0], 2'b00};
                end else begin
                    do_q  <= {tx_sh[BYTE_W-1], 1'b0};
                    tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assert_dual_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> (cnt < CNT_W'(HALF)));

    assert_abort_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr) |=> (cnt == '0 && !mode_q));

endmodule

// File: rtl/spi_flash_fe.sv
module spi_flash_fe
    import spi_fe_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              hold_n,
    input  logic [1:0]        io_i,
    output logic [1:0]        io_o,
    output logic [1:0]        io_oe,
    input  logic              dual_req,
    input  logic              tx_en,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              cmd_valid,
    output logic              data_valid
);
    fe_state_t state;
    logic      held, rise, fall, eff_dual;
    logic      cmd_pulse, data_pulse;
    logic [1:0] do_q;

    spi_fe_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .hold_n   (hold_n),
        .cmd_done (cmd_pulse),
        .state    (state),
        .held     (held),
        .rise     (rise),
        .fall     (fall)
    );

    spi_fe_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (cs_n),
        .rise       (rise),
        .fall       (fall),
        .io_i       (io_i),
        .dual_req   (dual_req),
        .tx_byte    (tx_byte),
        .rx_byte    (rx_byte),
        .cmd_pulse  (cmd_pulse),
        .data_pulse (data_pulse),
        .eff_dual   (eff_dual),
        .do_q       (do_q)
    );

    always_comb begin
        io_o       = do_q;
        cmd_valid  = cmd_pulse;
        data_valid = data_pulse;
        if (state == ST_DATA && !held && tx_en)
            io_oe = eff_dual ? 2'b11 : 2'b10;
        else
            io_oe = 2'b00;
    end

    assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> (io_oe == 2'b00));

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, data_valid}));

endmodule

// File: tb/sim_spi_flash_fe.sv
module sim_spi_flash_fe;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b0;
    logic       sclk = 1'b0;
    logic       hold_n = 1'b1;
    logic [1:0] io_i = 2'b00;
    logic [1:0] io_o, io_oe;
    logic       dual_req = 1'b0;
    logic       tx_en = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic [7:0] rx_byte;
    logic       cmd_valid, data_valid;

    int n_checks = 0;
    int n_fail = 0;
    int n_cmd = 0;
    int n_data = 0;
    logic [7:0] last_cmd = 8'h00;
    logic [7:0] last_data = 8'h00;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_flash_fe #(.BYTE_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .hold_n(hold_n),
        .io_i(io_i), .io_o(io_o), .io_oe(io_oe), .dual_req(dual_req),
        .tx_en(tx_en), .tx_byte(tx_byte), .rx_byte(rx_byte),
        .cmd_valid(cmd_valid), .data_valid(data_valid)
    );

    always @(posedge clk) begin
        if (cmd_valid)  begin n_cmd++;  last_cmd  = rx_byte; end
        if (data_valid) begin n_data++; last_data = rx_byte; end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cyc(input logic [1:0] d);
        io_i = d; sclk = 1'b1; waitc(3);
        sclk = 1'b0; waitc(3);
    endtask

    task automatic send1(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) cyc({1'b0, b[i]});
    endtask

    task automatic send2(input logic [7:0] b);
        for (int i = 3; i >= 0; i--) cyc(b[2*i+1 -: 2]);
    endtask

    task automatic sel;   cs_n = 1'b0; waitc(3); endtask
    task automatic desel; cs_n = 1'b1; waitc(3); endtask

    initial begin
        int c0;
        waitc(3); rst_n = 1'b1; waitc(2);
        // R2: selected through reset, no select edge yet
        chk("R1 reset oe", io_oe, 0);
        send1(8'hA5); waitc(2);
        chk("R2 locked no cmd", n_cmd, 0);
        desel;
        chk("R1 deselected oe", io_oe, 0);
        sel; send1(8'h3C); waitc(2);
        chk("R2 accepted after edge", n_cmd, 1);
        chk("R3 cmd value", last_cmd, 8'h3C);
        desel;

        // R3/R4 sweep of all byte values, single line
        for (int v = 0; v < 256; v++) begin
            c0 = n_cmd;
            sel; send1(v[7:0]); waitc(2);
            chk("R3 sweep cmd count", n_cmd, c0 + 1);
            chk("R3 sweep cmd", last_cmd, v);
            send1(~v[7:0]); waitc(2);
            chk("R4 sweep data", last_data, (~v) & 8'hFF);
            desel;
        end

        // R5 dual sweep; command stays single even with dual_req high
        for (int v = 0; v < 256; v++) begin
            c0 = n_data;
            dual_req = 1'b1;
            sel; send1(8'h3B); waitc(2);
            chk("R5 cmd single", last_cmd, 8'h3B);
            send2(v[7:0]); waitc(2);
            chk("R5 dual data", last_data, v);
            chk("R5 dual one strobe", n_data, c0 + 1);
            desel; dual_req = 1'b0;
        end

        // R6 single read, two bytes
        tx_en = 1'b1; tx_byte = 8'hC6;
        sel; send1(8'h03);
        tx_byte = 8'h5A;
        for (int k = 7; k >= 0; k--) begin
            chk("R6 oe single", io_oe, 2'b10);
            chk("R6 read bit b0", io_o[1], (8'hC6 >> k) & 1);
            cyc(2'b00);
        end
        for (int k = 7; k >= 0; k--) begin
            chk("R6 read bit b1", io_o[1], (8'h5A >> k) & 1);
            cyc(2'b00);
        end
        desel;
        chk("R1 oe after read", io_oe, 0);

        // R7 dual read
        tx_byte = 8'hB4; dual_req = 1'b1;
        sel; send1(8'h3B);
        tx_byte = 8'h1E;
        for (int k = 3; k >= 0; k--) begin
            chk("R7 oe dual", io_oe, 2'b11);
            chk("R7 dual pair b0", io_o, (8'hB4 >> (2*k)) & 3);
            cyc(2'b00);
        end
        for (int k = 3; k >= 0; k--) begin
            chk("R7 dual pair b1", io_o, (8'h1E >> (2*k)) & 3);
            cyc(2'b00);
        end
        desel; dual_req = 1'b0;

        // R8/R9 hold during single read, requested with sclk low
        tx_byte = 8'h96;
        sel; send1(8'h0B);
        for (int k = 7; k >= 5; k--) cyc(2'b00);
        hold_n = 1'b0; waitc(3);
        chk("R8 held oe", io_oe, 0);
        for (int j = 0; j < 3; j++) cyc(2'b11);
        hold_n = 1'b1; waitc(3);
        chk("R9 resume oe", io_oe, 2'b10);
        for (int k = 4; k >= 0; k--) begin
            chk("R9 resume read bit", io_o[1], (8'h96 >> k) & 1);
            cyc(2'b00);
        end
        desel;

        // R8 hold requested while sclk high waits for sclk low
        sel; send1(8'h0B);
        io_i = 2'b00; sclk = 1'b1; waitc(3);
        hold_n = 1'b0; waitc(3);
        chk("R8 deferred while high", io_oe, 2'b10);
        sclk = 1'b0; waitc(3);
        chk("R8 held after low", io_oe, 0);
        hold_n = 1'b1; waitc(3);
        chk("R9 next bit after deferred hold", io_o[1], (8'h96 >> 6) & 1);
        desel; tx_en = 1'b0;

        // R9 hold inside command byte
        sel;
        for (int i = 7; i >= 4; i--) cyc({1'b0, 8'hD2 >> i});
        hold_n = 1'b0; waitc(3);
        for (int j = 0; j < 4; j++) cyc(2'b01);
        hold_n = 1'b1; waitc(3);
        for (int i = 3; i >= 0; i--) cyc({1'b0, 8'hD2 >> i});
        waitc(2);
        chk("R9 cmd across hold", last_cmd, 8'hD2);
        desel;

        // R10 abort mid command and mid dual byte
        c0 = n_cmd;
        sel;
        for (int i = 0; i < 5; i++) cyc(2'b01);
        desel;
        chk("R10 no cmd on abort", n_cmd, c0);
        dual_req = 1'b1;
        sel; send1(8'h3B); cyc(2'b11); cyc(2'b11); desel;
        dual_req = 1'b0;
        sel; send1(8'h9E); send1(8'h47); waitc(2);
        chk("R10 fresh cmd", last_cmd, 8'h9E);
        chk("R10 single after abort", last_data, 8'h47);
        desel;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule